// File: doc/BRIEF.md
# Lockstep Retirement Comparator

Two processor implementations run the same program in lockstep. For every instruction it retires, each side hands this block a record. The record holds the general register file, the processor status word, a count of bus operations, and the ordered list of those operations, each with an address, a kind and data. The comparison works on whole retired instructions, not on individual signals cycle by cycle. Each side writes into its own record FIFO, so the two sides can retire the same instruction in different clock cycles and still be matched in program order.

A pair is compared once both FIFO heads are present. Each comparison produces a one-cycle done pulse. At the first difference the block sets a sticky error flag. It also holds the zero-based retirement index of the failing pair and a code naming the field that differed. The block does not build the records and does not recover from a mismatch; a reset clears it.

Top module: `lockstep_cmp`

## Requirements
- R1: A side accepts a record at a rising clock edge where its valid and ready are both high. Ready is low exactly while that side's FIFO holds DEPTH records (default 4), and the other side's ready is unaffected.
- R2: Records are paired strictly in arrival order per side: the k-th record of side A is compared with the k-th record of side B, whatever cycles they arrived in.
- R3: Take E as the edge at which the later record of a pair is accepted into an empty FIFO. Then cmp_done_o is low in the cycle after E and high for one cycle after edge E+1.
- R4: All general registers are compared. Register r occupies bits [r*16 +: 16] of the register bus. A difference reports the lowest differing r as code r (0 to 7).
- R5: The status word is compared, and a difference reports code 8.
- R6: The bus operation counts (0 to 8) are compared, and a difference reports code 9.
- R7: Bus entry k occupies bits [k*34 +: 34] of the operation bus. Within an entry, data is in [15:0], kind in [17:16] (00 read, 01 word write, 10 byte write, 11 fetch) and address in [33:18]. Entries with k below the count are compared in every field, and a difference reports code 16+k. Entries at or above the count have no effect.
- R8: When several fields differ, the lowest code is reported: registers, then status word, then count, then entries in order.
- R9: err_o is set by the first mismatching pair and stays set. err_code_o and err_index_o keep that pair's code and zero-based pair index, and later pairs change none of them.
- R10: After reset err_o, err_code_o, err_index_o and cmp_done_o are zero and both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Side A record valid |
| a_ready_o | output | 1 | Side A FIFO can accept |
| a_regs_i | input | 128 | Side A register values, register r in [r*16 +: 16] |
| a_psw_i | input | 16 | Side A status word |
| a_cnt_i | input | 4 | Side A bus operation count |
| a_ops_i | input | 272 | Side A bus operations, entry k in [k*34 +: 34] |
| b_valid_i | input | 1 | Side B record valid |
| b_ready_o | output | 1 | Side B FIFO can accept |
| b_regs_i | input | 128 | Side B register values |
| b_psw_i | input | 16 | Side B status word |
| b_cnt_i | input | 4 | Side B bus operation count |
| b_ops_i | input | 272 | Side B bus operations |
| cmp_done_o | output | 1 | One-cycle pulse per compared pair |
| err_o | output | 1 | Sticky mismatch flag |
| err_code_o | output | 5 | Field code of the first mismatch |
| err_index_o | output | 16 | Zero-based pair index of the first mismatch |

## Verification
A pair pushed at one edge reaches the FIFO heads after that edge. It is compared and the result registered at the next edge, so cmp_done_o and the error outputs are due one full cycle after the push cycle. The bench drives inputs on falling edges. It samples cmp_done_o low at the first falling edge after the push and high at the second, and reads the error outputs at that same second edge. Tests that stack records on one side wait out the drain of every queued pair before they sample. A sweep runs every register, every bus entry and each entry field, with the expected code computed from the field position.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_PSW = 5'd8;
  localparam code_t CODE_CNT = 5'd9;
  localparam int ENTRY_BASE = 16;
  typedef enum logic [1:0] {
    BUS_READ   = 2'b00,
    BUS_WRITE  = 2'b01,
    BUS_WRITEB = 2'b10,
    BUS_FETCH  = 2'b11
  } bus_kind_e;
endpackage

// File: rtl/rec_fifo.sv
module rec_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full_o  = (count == CNT_W'(DEPTH));
  assign empty_o = (count == '0);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count < CNT_W'(DEPTH))); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count != '0)); // R2
endmodule

// File: rtl/rec_cmp.sv
module rec_cmp
  import lockstep_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int MAX_OPS  = 8,
  parameter int CNT_W    = 4
) (
  input  logic [NUM_REGS*DATA_W-1:0]       a_regs_i,
  input  logic [DATA_W-1:0]                a_psw_i,
  input  logic [CNT_W-1:0]                 a_cnt_i,
  input  logic [MAX_OPS*(2*DATA_W+2)-1:0]  a_ops_i,
  input  logic [NUM_REGS*DATA_W-1:0]       b_regs_i,
  input  logic [DATA_W-1:0]                b_psw_i,
  input  logic [CNT_W-1:0]                 b_cnt_i,
  input  logic [MAX_OPS*(2*DATA_W+2)-1:0]  b_ops_i,
  output logic                             diff_o,
  output code_t                            code_o
);
  localparam int OP_W = 2 * DATA_W + 2;

  logic [NUM_REGS-1:0] reg_diff;
  logic [MAX_OPS-1:0]  op_diff;
  logic                psw_diff, cnt_diff;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign reg_diff[r] = a_regs_i[r*DATA_W +: DATA_W] != b_regs_i[r*DATA_W +: DATA_W];
  end

  // entries past the count are don't-care
  for (genvar k = 0; k < MAX_OPS; k++) begin : g_op
    localparam logic [CNT_W-1:0] KIDX = CNT_W'(k);
    assign op_diff[k] = (KIDX < a_cnt_i) &&
                        (a_ops_i[k*OP_W +: OP_W] != b_ops_i[k*OP_W +: OP_W]);
  end

  assign psw_diff = a_psw_i != b_psw_i;
  assign cnt_diff = a_cnt_i != b_cnt_i;
  assign diff_o   = (|reg_diff) | psw_diff | cnt_diff | (|op_diff);

  // descending scan, lowest code written last wins
  always_comb begin
    code_o = '0;
    for (int k = MAX_OPS - 1; k >= 0; k--) begin
      if (op_diff[k]) code_o = code_t'(ENTRY_BASE + k);
    end
    if (cnt_diff) code_o = CODE_CNT;
    if (psw_diff) code_o = CODE_PSW;
    for (int r = NUM_REGS - 1; r >= 0; r--) begin
      if (reg_diff[r]) code_o = code_t'(r);
    end
  end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lockstep_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int MAX_OPS  = 8,
  parameter int DEPTH    = 4,
  parameter int IDX_W    = 16
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     a_valid_i,
  output logic                                     a_ready_o,
  input  logic [NUM_REGS*DATA_W-1:0]               a_regs_i,
  input  logic [DATA_W-1:0]                        a_psw_i,
  input  logic [$clog2(MAX_OPS+1)-1:0]             a_cnt_i,
  input  logic [MAX_OPS*(2*DATA_W+2)-1:0]          a_ops_i,
  input  logic                                     b_valid_i,
  output logic                                     b_ready_o,
  input  logic [NUM_REGS*DATA_W-1:0]               b_regs_i,
  input  logic [DATA_W-1:0]                        b_psw_i,
  input  logic [$clog2(MAX_OPS+1)-1:0]             b_cnt_i,
  input  logic [MAX_OPS*(2*DATA_W+2)-1:0]          b_ops_i,
  output logic                                     cmp_done_o,
  output logic                                     err_o,
  output logic [CODE_W-1:0]                        err_code_o,
  output logic [IDX_W-1:0]                         err_index_o
);
  localparam int CNT_W  = $clog2(MAX_OPS + 1);
  localparam int OP_W   = 2 * DATA_W + 2;
  localparam int REGS_W = NUM_REGS * DATA_W;
  localparam int OPS_W  = MAX_OPS * OP_W;
  localparam int REC_W  = OPS_W + CNT_W + DATA_W + REGS_W;

  logic [REC_W-1:0] a_head, b_head;
  logic a_full, b_full, a_empty, b_empty;
  logic a_push, b_push, pop;
  logic diff;
  code_t code;

  logic done_q, err_q;
  code_t code_q;
  logic [IDX_W-1:0] idx_q, err_idx_q;

  assign a_ready_o = !a_full;
  assign b_ready_o = !b_full;
  assign a_push    = a_valid_i && !a_full;
  assign b_push    = b_valid_i && !b_full;
  assign pop       = !a_empty && !b_empty;

  rec_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo_a (
    .clk_i, .rst_ni,
    .push_i (a_push),
    .data_i ({a_ops_i, a_cnt_i, a_psw_i, a_regs_i}),
    .pop_i  (pop),
    .head_o (a_head),
    .full_o (a_full),
    .empty_o(a_empty)
  );

  rec_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo_b (
    .clk_i, .rst_ni,
    .push_i (b_push),
    .data_i ({b_ops_i, b_cnt_i, b_psw_i, b_regs_i}),
    .pop_i  (pop),
    .head_o (b_head),
    .full_o (b_full),
    .empty_o(b_empty)
  );

  rec_cmp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .MAX_OPS(MAX_OPS), .CNT_W(CNT_W)) u_cmp (
    .a_regs_i(a_head[REGS_W-1:0]),
    .a_psw_i (a_head[REGS_W +: DATA_W]),
    .a_cnt_i (a_head[REGS_W+DATA_W +: CNT_W]),
    .a_ops_i (a_head[REC_W-1 -: OPS_W]),
    .b_regs_i(b_head[REGS_W-1:0]),
    .b_psw_i (b_head[REGS_W +: DATA_W]),
    .b_cnt_i (b_head[REGS_W+DATA_W +: CNT_W]),
    .b_ops_i (b_head[REC_W-1 -: OPS_W]),
    .diff_o  (diff),
    .code_o  (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= '0;
      idx_q     <= '0;
      err_idx_q <= '0;
    end else begin
      done_q <= pop;
      if (pop) begin
        idx_q <= idx_q + 1'b1;
        if (diff && !err_q) begin
          err_q     <= 1'b1;
          code_q    <= code;
          err_idx_q <= idx_q;
        end
      end
    end
  end

  assign cmp_done_o  = done_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;
  assign err_index_o = err_idx_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> ($stable(err_code_o) && $stable(err_index_o))); // R9
  AST_ERR_ON_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> cmp_done_o); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((err_code_o <= CODE_CNT) ||
               (err_code_o >= code_t'(ENTRY_BASE)
                && err_code_o < code_t'(ENTRY_BASE + MAX_OPS)))); // R7
endmodule

// File: tb/lockstep_cmp_tb.sv
`timescale 1ns/1ps
module lockstep_cmp_tb;
  localparam int NR = 8, DW = 16, MO = 8, CW = 4, OPW = 34, IW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic a_ready, b_ready, done, err;
  logic [NR*DW-1:0] a_regs, b_regs;
  logic [DW-1:0] a_psw, b_psw;
  logic [CW-1:0] a_cnt, b_cnt;
  logic [MO*OPW-1:0] a_ops, b_ops;
  logic [4:0] code;
  logic [IW-1:0] idx;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lockstep_cmp u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_regs_i(a_regs), .a_psw_i(a_psw),
    .a_cnt_i(a_cnt), .a_ops_i(a_ops),
    .b_valid_i(b_valid), .b_ready_o(b_ready), .b_regs_i(b_regs), .b_psw_i(b_psw),
    .b_cnt_i(b_cnt), .b_ops_i(b_ops),
    .cmp_done_o(done), .err_o(err), .err_code_o(code), .err_index_o(idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic base_a(int s);
    for (int r = 0; r < NR; r++) a_regs[r*DW +: DW] = DW'(s * 97 + r * 13 + 1);
    a_psw = DW'(s ^ 16'h5a5a);
    a_cnt = CW'(s % 9);
    for (int k = 0; k < MO; k++) begin
      a_ops[k*OPW +: 16]      = DW'(~(s * 31 + k));
      a_ops[k*OPW + 16 +: 2]  = 2'(k);
      a_ops[k*OPW + 18 +: 16] = DW'(s * 256 + k);
    end
  endtask

  task automatic base_b(int s);
    base_a(s);
    b_regs = a_regs; b_psw = a_psw; b_cnt = a_cnt; b_ops = a_ops;
  endtask

  task automatic base(int s);
    base_b(s);
  endtask

  task automatic do_reset();
    a_valid = 1'b0; b_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_both();
    a_valid = 1'b1; b_valid = 1'b1;
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic push_matching(int n, int seed);
    for (int i = 0; i < n; i++) begin
      base(seed + i);
      push_both();
      @(negedge clk);
    end
  endtask

  task automatic push_and_check(string req, logic exp_err, int exp_code, int exp_idx);
    push_both();
    chk({req, " R3 done not early"}, 32'(done), 0);
    @(negedge clk);
    chk({req, " R3 done"}, 32'(done), 1);
    chk({req, " err"}, 32'(err), 32'(exp_err));
    if (exp_err) begin
      chk({req, " code"}, 32'(code), 32'(exp_code));
      chk({req, " R9 index"}, 32'(idx), 32'(exp_idx));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    base(0);
    do_reset();
    // R10
    chk("R10 err", 32'(err), 0);
    chk("R10 code", 32'(code), 0);
    chk("R10 index", 32'(idx), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 a_ready", 32'(a_ready), 1);
    chk("R10 b_ready", 32'(b_ready), 1);

    // matching records stay in lockstep
    for (int s = 0; s < 10; s++) begin
      base(s);
      push_and_check("R4 match", 1'b0, 0, 0);
    end

    // R4: every register
    for (int r = 0; r < NR; r++) begin
      do_reset();
      push_matching(r % 3, 40);
      base(r + 20);
      b_regs[r*DW + r] = ~b_regs[r*DW + r];
      push_and_check("R4 reg", 1'b1, r, r % 3);
    end

    // R5
    do_reset();
    base(3); b_psw[15] = ~b_psw[15];
    push_and_check("R5 psw", 1'b1, 8, 0);

    // R8: register beats psw
    do_reset();
    base(4); b_psw[0] = ~b_psw[0]; b_regs[5*DW + 2] = ~b_regs[5*DW + 2];
    push_and_check("R8 reg over psw", 1'b1, 5, 0);

    // R6 and R8: count beats entry
    do_reset();
    base(5); a_cnt = 4'd3; b_cnt = 4'd4; b_ops[0] = ~b_ops[0];
    push_and_check("R6 count", 1'b1, 9, 0);

    // R8: psw beats count
    do_reset();
    base(6); b_cnt = 4'd1; a_cnt = 4'd2; b_psw[3] = ~b_psw[3];
    push_and_check("R8 psw over count", 1'b1, 8, 0);

    // R7: every entry, field chosen per entry
    for (int k = 0; k < MO; k++) begin
      int off;
      off = (k % 3 == 0) ? 0 : (k % 3 == 1) ? 16 : 20;
      do_reset();
      push_matching(k % 2, 60);
      base(k + 70); a_cnt = 4'd8; b_cnt = 4'd8;
      b_ops[k*OPW + off] = ~b_ops[k*OPW + off];
      if (k < MO - 1) b_ops[(k+1)*OPW + 5] = ~b_ops[(k+1)*OPW + 5];
      push_and_check("R7 entry", 1'b1, 16 + k, k % 2);
    end

    // R7: entries past the count ignored
    do_reset();
    base(7); a_cnt = 4'd3; b_cnt = 4'd3;
    b_ops[5*OPW + 17] = ~b_ops[5*OPW + 17]; b_ops[7*OPW + 30] = ~b_ops[7*OPW + 30];
    push_and_check("R7 beyond count", 1'b0, 0, 0);
    base(8); a_cnt = 4'd0; b_cnt = 4'd0; b_ops = ~a_ops;
    push_and_check("R7 zero count", 1'b0, 0, 0);
    base(9); a_cnt = 4'd3; b_cnt = 4'd3; b_ops[2*OPW + 16] = ~b_ops[2*OPW + 16];
    push_and_check("R7 last counted entry", 1'b1, 18, 2);

    // R9: later mismatch leaves latched values
    base(10); b_regs[0] = ~b_regs[0];
    push_and_check("R9 sticky", 1'b1, 18, 2);

    // R1 and R2: stack side A, then side B
    do_reset();
    for (int i = 0; i < 4; i++) begin
      base_a(80 + i);
      a_valid = 1'b1;
      @(negedge clk);
    end
    a_valid = 1'b0;
    chk("R1 a_ready low when full", 32'(a_ready), 0);
    chk("R1 b_ready unaffected", 32'(b_ready), 1);
    chk("R2 no compare one side", 32'(done), 0);
    for (int i = 0; i < 4; i++) begin
      base_b(80 + i);
      if (i == 2) b_psw[7] = ~b_psw[7];
      b_valid = 1'b1;
      @(negedge clk);
    end
    b_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 a_ready after drain", 32'(a_ready), 1);
    chk("R2 err", 32'(err), 1);
    chk("R2 code", 32'(code), 8);
    chk("R2 index", 32'(idx), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule